// File: doc/BRIEF.md
# Two-Ring Client/Server Request Interconnect

This block joins a build-time number of clients to one central server over two one-way chains of registered stops. Each client has a slot on the outbound chain. A request that a client injects is tagged with that client's fixed index. It then moves one stop per cycle toward the server, which sees a single stream of tagged requests.

The server answers by placing a tagged response on the return chain. That chain passes every client in index order. Each stop keeps a response whose tag equals its own index and hands it to the local client. It passes any other response to the next stop.

Every hop uses a valid/ready handshake. A stop therefore holds its item until the next stage takes it. Nothing is lost or copied, even when the server or a client applies backpressure.

Top module: `ring_svc_top`

## Requirements
- R1: After reset, every valid output (server request, all client responses) is low, and every client request ready and the server response ready are high.
- R2: A request accepted from client k reaches the server with id field equal to k (id is the plain binary client index, 0 to NUM_CLIENTS-1) and with its data unchanged.
- R3: The requests of one client reach the server in the order that client issued them.
- R4: A request already on the outbound chain takes priority over a new injection at the same stop: a client's request waits while an upstream stop offers an item to its stop.
- R5: A response with id k is offered only on client k's response port. Response ids presented by the server are always below NUM_CLIENTS.
- R6: A response held at a client whose response ready is low keeps its valid and data stable, and no response behind it is carried past that stop until it is taken.
- R7: Every accepted request reaches the server exactly once, and every accepted response reaches its client exactly once.
- R8: While the server holds its request ready low, the server request output keeps valid, id and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req_valid | input | NUM_CLIENTS | Per-client request valid |
| cli_req_data | input | NUM_CLIENTS*DATA_W | Per-client request payloads, client k at bits k*DATA_W upward |
| cli_req_ready | output | NUM_CLIENTS | Per-client request accepted |
| cli_rsp_valid | output | NUM_CLIENTS | Per-client response valid |
| cli_rsp_data | output | NUM_CLIENTS*DATA_W | Per-client response payloads |
| cli_rsp_ready | input | NUM_CLIENTS | Per-client response accepted |
| srv_req_valid | output | 1 | Request to server valid |
| srv_req_id | output | ID_W | Index of the issuing client |
| srv_req_data | output | DATA_W | Request payload |
| srv_req_ready | input | 1 | Server takes request |
| srv_rsp_valid | input | 1 | Server response valid |
| srv_rsp_id | input | ID_W | Destination client index |
| srv_rsp_data | input | DATA_W | Response payload |
| srv_rsp_ready | output | 1 | Response chain accepts |

## Verification
The assertions check four properties on every cycle. Stalled stop outputs hold their contents. A local injection lands in its stop tagged with that stop's index. An upstream item taken by a stop appears there on the next cycle. The server never presents an out-of-range response id.

Some behaviours only the bench's scenarios can show. These are per-client ordering, exactly-once delivery across mixed backpressure patterns, and that a stalled response blocks the traffic behind it. They also include the ordering effect of chain priority: an item already in flight overtakes a later injection at a downstream stop.

// File: rtl/ring_svc_pkg.sv
package ring_svc_pkg;

  // Width of the client index field for a given client count.
  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ring_req_stop.sv
module ring_req_stop #(
  parameter int ID_W   = 2,
  parameter int DATA_W = 16,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic [ID_W-1:0]   up_id,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ready,
  input  logic              loc_valid,
  input  logic [DATA_W-1:0] loc_data,
  output logic              loc_ready,
  output logic              dn_valid,
  output logic [ID_W-1:0]   dn_id,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_ready
);

  localparam logic [ID_W-1:0] OWN_TAG = ID_W'(MY_ID);

  logic              full_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;
  logic              can_load;

  assign can_load  = !full_q || dn_ready;
  assign up_ready  = can_load;
  // in-flight traffic wins over a new local injection
  assign loc_ready = can_load && !up_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (can_load) begin
      full_q <= up_valid || loc_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (can_load) begin
      if (up_valid) begin
        id_q   <= up_id;
        data_q <= up_data;
      end else begin
        id_q   <= OWN_TAG;
        data_q <= loc_data;
      end
    end
  end

  assign dn_valid = full_q;
  assign dn_id    = id_q;
  assign dn_data  = data_q;

  // R8: a stalled hop keeps its item
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_id) && $stable(dn_data)));

  // R2: a local injection is tagged with this stop's index
  a_r2_local_tag: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_ready) |=> (dn_valid && dn_id == OWN_TAG && dn_data == $past(loc_data)));

  // R4: an upstream item taken by this stop is the one presented next cycle
  a_r4_ring_first: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> (dn_valid && dn_id == $past(up_id) && dn_data == $past(up_data)));

endmodule

// File: rtl/ring_rsp_stop.sv
module ring_rsp_stop #(
  parameter int ID_W   = 2,
  parameter int DATA_W = 16,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic [ID_W-1:0]   up_id,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ready,
  output logic              loc_valid,
  output logic [DATA_W-1:0] loc_data,
  input  logic              loc_ready,
  output logic              dn_valid,
  output logic [ID_W-1:0]   dn_id,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_ready
);

  localparam logic [ID_W-1:0] OWN_TAG = ID_W'(MY_ID);

  logic              full_q;
  logic              hit_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;
  logic              drain;
  logic              can_load;

  assign drain    = full_q && (hit_q ? loc_ready : dn_ready);
  assign can_load = !full_q || drain;
  assign up_ready = can_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (can_load) begin
      full_q <= up_valid;
    end
  end

  // match is resolved on entry so the outputs come straight from flops
  always_ff @(posedge clk) begin
    if (can_load) begin
      hit_q  <= (up_id == OWN_TAG);
      id_q   <= up_id;
      data_q <= up_data;
    end
  end

  assign loc_valid = full_q && hit_q;
  assign loc_data  = data_q;
  assign dn_valid  = full_q && !hit_q;
  assign dn_id     = id_q;
  assign dn_data   = data_q;

  // R6: a response waiting on its client stays put
  a_r6_local_stall: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_data)));

  // R6: a forwarded response waiting downstream stays put
  a_r6_fwd_stall: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_id) && $stable(dn_data)));

  // R5: a foreign response taken in is never offered locally
  a_r5_foreign_passes: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready && up_id != OWN_TAG) |=> (!loc_valid && dn_valid));

endmodule

// File: rtl/ring_svc_top.sv
module ring_svc_top
  import ring_svc_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int DATA_W      = 16,
  parameter int ID_W        = id_width(NUM_CLIENTS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CLIENTS-1:0]        cli_req_valid,
  input  logic [NUM_CLIENTS*DATA_W-1:0] cli_req_data,
  output logic [NUM_CLIENTS-1:0]        cli_req_ready,
  output logic [NUM_CLIENTS-1:0]        cli_rsp_valid,
  output logic [NUM_CLIENTS*DATA_W-1:0] cli_rsp_data,
  input  logic [NUM_CLIENTS-1:0]        cli_rsp_ready,
  output logic                          srv_req_valid,
  output logic [ID_W-1:0]               srv_req_id,
  output logic [DATA_W-1:0]             srv_req_data,
  input  logic                          srv_req_ready,
  input  logic                          srv_rsp_valid,
  input  logic [ID_W-1:0]               srv_rsp_id,
  input  logic [DATA_W-1:0]             srv_rsp_data,
  output logic                          srv_rsp_ready
);

  localparam int HOPS = NUM_CLIENTS + 1;

  // outbound chain: index k feeds stop k, index NUM_CLIENTS is the server
  logic              q_v [HOPS];
  logic [ID_W-1:0]   q_id[HOPS];
  logic [DATA_W-1:0] q_d [HOPS];
  logic              q_r [HOPS];

  // return chain: index 0 is the server, stop k drives index k+1
  logic              p_v [HOPS];
  logic [ID_W-1:0]   p_id[HOPS];
  logic [DATA_W-1:0] p_d [HOPS];
  logic              p_r [HOPS];

  assign q_v[0]  = 1'b0;
  assign q_id[0] = '0;
  assign q_d[0]  = '0;
  assign q_r[NUM_CLIENTS] = srv_req_ready;

  assign srv_req_valid = q_v[NUM_CLIENTS];
  assign srv_req_id    = q_id[NUM_CLIENTS];
  assign srv_req_data  = q_d[NUM_CLIENTS];

  assign p_v[0]        = srv_rsp_valid;
  assign p_id[0]       = srv_rsp_id;
  assign p_d[0]        = srv_rsp_data;
  assign srv_rsp_ready = p_r[0];
  // nothing may leave the far end of the return chain
  assign p_r[NUM_CLIENTS] = 1'b0;

  logic unused_ends;
  assign unused_ends = ^{q_r[0], p_v[NUM_CLIENTS], p_id[NUM_CLIENTS], p_d[NUM_CLIENTS]};

  for (genvar k = 0; k < NUM_CLIENTS; k++) begin : g_stop
    ring_req_stop #(
      .ID_W  (ID_W),
      .DATA_W(DATA_W),
      .MY_ID (k)
    ) u_req (
      .clk      (clk),
      .rst      (rst),
      .up_valid (q_v[k]),
      .up_id    (q_id[k]),
      .up_data  (q_d[k]),
      .up_ready (q_r[k]),
      .loc_valid(cli_req_valid[k]),
      .loc_data (cli_req_data[k*DATA_W +: DATA_W]),
      .loc_ready(cli_req_ready[k]),
      .dn_valid (q_v[k+1]),
      .dn_id    (q_id[k+1]),
      .dn_data  (q_d[k+1]),
      .dn_ready (q_r[k+1])
    );

    ring_rsp_stop #(
      .ID_W  (ID_W),
      .DATA_W(DATA_W),
      .MY_ID (k)
    ) u_rsp (
      .clk      (clk),
      .rst      (rst),
      .up_valid (p_v[k]),
      .up_id    (p_id[k]),
      .up_data  (p_d[k]),
      .up_ready (p_r[k]),
      .loc_valid(cli_rsp_valid[k]),
      .loc_data (cli_rsp_data[k*DATA_W +: DATA_W]),
      .loc_ready(cli_rsp_ready[k]),
      .dn_valid (p_v[k+1]),
      .dn_id    (p_id[k+1]),
      .dn_data  (p_d[k+1]),
      .dn_ready (p_r[k+1])
    );
  end

  // R5: the server only addresses clients that exist
  a_r5_id_range: assert property (@(posedge clk) disable iff (rst)
    srv_rsp_valid |-> ({1'b0, srv_rsp_id} < (ID_W+1)'(NUM_CLIENTS)));

endmodule

// File: tb/ring_svc_top_tb.sv
module ring_svc_top_tb;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    crv;
  logic [N*DW-1:0] crd;
  logic [N-1:0]    crr;
  logic [N-1:0]    cpv;
  logic [N*DW-1:0] cpd;
  logic [N-1:0]    cpr;
  logic            sqv;
  logic [IW-1:0]   sqi;
  logic [DW-1:0]   sqd;
  logic            sqr;
  logic            spv;
  logic [IW-1:0]   spi;
  logic [DW-1:0]   spd;
  logic            spr;

  int checks = 0;
  int errors = 0;

  typedef logic [DW-1:0] dq_t[$];
  dq_t exp_req[N];
  dq_t exp_rsp[N];
  logic [IW-1:0] todo_id[$];
  logic [DW-1:0] todo_d[$];
  int seq_ctr[N];

  always #10 clk = ~clk;

  ring_svc_top #(.NUM_CLIENTS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .cli_req_valid(crv), .cli_req_data(crd), .cli_req_ready(crr),
    .cli_rsp_valid(cpv), .cli_rsp_data(cpd), .cli_rsp_ready(cpr),
    .srv_req_valid(sqv), .srv_req_id(sqi), .srv_req_data(sqd), .srv_req_ready(sqr),
    .srv_rsp_valid(spv), .srv_rsp_id(spi), .srv_rsp_data(spd), .srv_rsp_ready(spr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard phase: mode selects injection gaps and backpressure pattern
  task automatic run_phase(input int per_client, input int mode);
    int left[N];
    bit acc[N];
    bit srv_acc = 1'b0;
    int cyc = 0;
    bit quiet;
    for (int c = 0; c < N; c++) begin
      left[c] = per_client;
      acc[c]  = 1'b0;
    end
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      for (int c = 0; c < N; c++) begin
        if (crv[c] && acc[c]) crv[c] = 1'b0;
        if (!crv[c] && left[c] > 0 && ((cyc + c) % (mode + 1)) == 0) begin
          crd[c*DW +: DW] = {4'(c), 12'(seq_ctr[c])};
          seq_ctr[c]++;
          crv[c] = 1'b1;
          left[c]--;
        end
      end
      if (spv && srv_acc) spv = 1'b0;
      if (!spv && todo_id.size() > 0) begin
        spi = todo_id.pop_front();
        spd = todo_d.pop_front();
        spv = 1'b1;
      end
      for (int c = 0; c < N; c++) begin
        if (mode == 0)      cpr[c] = 1'b1;
        else if (mode == 1) cpr[c] = ((cyc + c) % 4) != 0;
        else                cpr[c] = ((cyc / 3 + c) % 2) == 0;
      end
      if (mode == 0)      sqr = 1'b1;
      else if (mode == 1) sqr = (cyc % 3) != 0;
      else                sqr = (cyc % 5) < 2;
      #5;
      for (int c = 0; c < N; c++) begin
        acc[c] = crv[c] && crr[c];
        if (acc[c]) exp_req[c].push_back(crd[c*DW +: DW]);
      end
      srv_acc = spv && spr;
      if (srv_acc) exp_rsp[spi].push_back(spd);
      if (sqv && sqr) begin
        if (exp_req[sqi].size() == 0) begin
          check(1'b0, "R7 request without issue", 32'(sqd), 32'hffff_ffff);
        end else begin
          logic [DW-1:0] e;
          e = exp_req[sqi].pop_front();
          check(sqd == e, "R3 request order", 32'(sqd), 32'(e));
          check(sqd[15:12] == 4'(sqi), "R2 id tag", 32'(sqi), 32'(sqd[15:12]));
        end
        todo_id.push_back(sqi);
        todo_d.push_back(~sqd);
      end
      for (int c = 0; c < N; c++) begin
        if (cpv[c] && cpr[c]) begin
          if (exp_rsp[c].size() == 0) begin
            check(1'b0, "R5 response at wrong client", 32'(c), 32'hffff_ffff);
          end else begin
            logic [DW-1:0] e;
            e = exp_rsp[c].pop_front();
            check(cpd[c*DW +: DW] == e, "R5 response routing", 32'(cpd[c*DW +: DW]), 32'(e));
          end
        end
      end
      quiet = !spv && (todo_id.size() == 0) && (crv == '0);
      for (int c = 0; c < N; c++) begin
        if (left[c] != 0 || exp_req[c].size() != 0 || exp_rsp[c].size() != 0) quiet = 1'b0;
      end
      if (quiet) break;
    end
    for (int c = 0; c < N; c++) begin
      check(exp_req[c].size() == 0 && exp_rsp[c].size() == 0 && left[c] == 0,
            "R7 all delivered", 32'(exp_req[c].size() + exp_rsp[c].size()), 32'd0);
    end
    sqr = 1'b1;
    cpr = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got[3];
    int n;
    bit c3acc;
    for (int c = 0; c < N; c++) seq_ctr[c] = 0;
    rst = 1'b1; crv = '0; crd = '0; cpr = '0; sqr = 1'b0;
    spv = 1'b0; spi = '0; spd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    // R1 reset state
    check(sqv == 1'b0, "R1 server valid", 32'(sqv), 32'd0);
    check(cpv == '0, "R1 response valid", 32'(cpv), 32'd0);
    check(crr == '1 && spr == 1'b1, "R1 readies", 32'({crr, spr}), 32'h1f);

    // R8 and R2: one request held at a stalled server
    @(negedge clk); sqr = 1'b0; crv[1] = 1'b1; crd[1*DW +: DW] = 16'h1123;
    #5 check(crr[1] == 1'b1, "R7 inject accepted", 32'(crr[1]), 32'd1);
    @(negedge clk); crv[1] = 1'b0;
    repeat (6) @(negedge clk);
    #5;
    check(sqv == 1'b1, "R8 held valid", 32'(sqv), 32'd1);
    check(sqi == 2'd1, "R2 id of client 1", 32'(sqi), 32'd1);
    check(sqd == 16'h1123, "R2 data unchanged", 32'(sqd), 32'h1123);
    @(negedge clk); #5;
    check(sqv == 1'b1 && sqd == 16'h1123, "R8 stable while stalled", 32'(sqd), 32'h1123);
    @(negedge clk); sqr = 1'b1;
    @(negedge clk); #5;
    check(sqv == 1'b0, "R7 no duplicate request", 32'(sqv), 32'd0);

    // R4: in-flight item from client 0 goes before a later client 3 injection
    @(negedge clk); sqr = 1'b0; crv[3] = 1'b1; crd[3*DW +: DW] = 16'h3001;
    #5 check(crr[3] == 1'b1, "R4 first inject", 32'(crr[3]), 32'd1);
    @(negedge clk); crv[3] = 1'b0; crv[0] = 1'b1; crd[0*DW +: DW] = 16'h0002;
    #5 check(crr[0] == 1'b1, "R4 upstream inject", 32'(crr[0]), 32'd1);
    @(negedge clk); crv[0] = 1'b0;
    repeat (5) @(negedge clk);
    crv[3] = 1'b1; crd[3*DW +: DW] = 16'h3003;
    #5 check(crr[3] == 1'b0, "R4 blocked injection", 32'(crr[3]), 32'd0);
    @(negedge clk); sqr = 1'b1;
    n = 0; c3acc = 1'b0;
    for (int i = 0; i < 10; i++) begin
      #5;
      if (crv[3] && crr[3]) c3acc = 1'b1;
      if (sqv && sqr && n < 3) begin got[n] = sqd; n++; end
      @(negedge clk);
      if (c3acc) crv[3] = 1'b0;
    end
    check(n == 3, "R7 three delivered", 32'(n), 32'd3);
    check(got[0] == 16'h3001, "R3 first item", 32'(got[0]), 32'h3001);
    check(got[1] == 16'h0002, "R4 ring item before injection", 32'(got[1]), 32'h0002);
    check(got[2] == 16'h3003, "R4 injection last", 32'(got[2]), 32'h3003);

    // R6 and R5: stalled response blocks one behind it
    cpr = '0;
    @(negedge clk); spv = 1'b1; spi = 2'd1; spd = 16'hBEEF;
    #5 check(spr == 1'b1, "R7 response accepted", 32'(spr), 32'd1);
    @(negedge clk); spi = 2'd3; spd = 16'hCAFE;
    #5 check(spr == 1'b1, "R7 second response accepted", 32'(spr), 32'd1);
    @(negedge clk); spv = 1'b0;
    repeat (5) @(negedge clk);
    #5;
    check(cpv == 4'b0010, "R5 only client 1 valid", 32'(cpv), 32'h2);
    check(cpd[1*DW +: DW] == 16'hBEEF, "R6 stalled data", 32'(cpd[1*DW +: DW]), 32'hBEEF);
    @(negedge clk); #5;
    check(cpv == 4'b0010 && cpd[1*DW +: DW] == 16'hBEEF, "R6 not passed while stalled",
          32'(cpv), 32'h2);
    @(negedge clk); cpr[1] = 1'b1;
    #5 check(cpv[1] == 1'b1, "R6 delivered on release", 32'(cpv[1]), 32'd1);
    @(negedge clk); cpr[1] = 1'b0;
    repeat (4) @(negedge clk);
    #5;
    check(cpv == 4'b1000, "R5 only client 3 valid", 32'(cpv), 32'h8);
    check(cpd[3*DW +: DW] == 16'hCAFE, "R5 client 3 data", 32'(cpd[3*DW +: DW]), 32'hCAFE);
    @(negedge clk); cpr[3] = 1'b1;
    @(negedge clk); cpr = '1;
    #5 check(cpv == '0, "R7 no duplicate response", 32'(cpv), 32'd0);

    // scoreboard phases under several traffic patterns
    run_phase(6, 0);
    run_phase(8, 1);
    run_phase(8, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule